// File: doc/BRIEF.md
# Memory-Mapped Converter Bus Interface

This block lets a successive-approximation converter sit on a processor bus as if it were a single memory location. The only controls it receives are an active-low chip select and an active-low read strobe. It turns edges and levels of these two pins into single-cycle start and reset requests for the conversion sequencer. It holds the finished result and presents it on an 8-bit bus that is modelled as a data word plus an output-enable. A ready output is high whenever no conversion is running. The processor can poll it, or use it as a wait/ready line.

The same decode serves three wiring styles. In static-RAM style, a write cycle (select low, read high) starts a conversion and a later read fetches the result. In ROM style, select is tied low and every read strobe both fetches the data and, on its release, restarts the converter. In slow-memory style, select and read are tied together: their common falling edge starts a conversion, ready stays low for the whole conversion, and the common rising edge resets and deselects the converter. Reads are destructive. Reading while a conversion runs is refused and flagged instead of being forwarded.

Both pins are asynchronous. Each passes through a two-stage synchronizer, and every request, flag and enable is registered. Any pin change therefore reaches the outputs on the third rising clock edge. The data bus has no back-pressure. The processor is expected to honour ready before it reads.

Top module: `cbus_iface`

## Requirements
- R1: After reset, ready_o is 1, dbus_oe is 0, dbus_data is 0, and start_req, reset_req and bus_err are 0.
- R2: While no conversion runs, a falling chip select with the read strobe high produces one start_req pulse. ready_o is 0 from that pulse until the cycle after seq_done is sampled.
- R3: A write cycle (chip select falling with the read strobe high) made while a conversion runs produces no start_req, and ready_o stays 0.
- R4: With chip select low, read strobe low and no conversion running, dbus_oe is 1 and dbus_data equals the seq_result value captured on the last seq_done.
- R5: dbus_oe is 0 whenever chip select is high, read strobe is high, or a conversion runs, and dbus_data is 0 whenever dbus_oe is 0.
- R6: Read strobe changes while chip select is high cause no pulse on any request output and leave dbus_oe at 0.
- R7: A rising read strobe whose preceding synchronized chip select was low produces a reset_req pulse. If chip select is still low in that same cycle, start_req pulses in the same cycle (restart); otherwise the converter becomes idle.
- R8: With chip select held low, the value read after a read-strobe release is the result of the conversion that the release started.
- R9: With both pins tied together, their common fall while idle starts a conversion with dbus_oe 0 and ready_o 0. Once done, dbus_oe is 1 with the result, and the common rise gives reset_req alone with dbus_oe back to 0 and ready_o 1.
- R10: A falling read strobe while chip select is low and a conversion runs gives a one-cycle bus_err pulse with no start_req or reset_req, and ready_o stays 0.
- R11: start_req, reset_req and bus_err are single-cycle pulses. Each appears on the third rising clock edge after the pin change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| seq_done | input | 1 | One-cycle pulse from the sequencer: conversion finished |
| seq_result | input | 8 | Conversion result, valid with seq_done |
| start_req | output | 1 | One-cycle request to begin a conversion |
| reset_req | output | 1 | One-cycle request to reset the converter |
| bus_err | output | 1 | One-cycle flag for a read attempted during conversion |
| ready_o | output | 1 | High when no conversion is running; wait line when low |
| dbus_oe | output | 1 | Data bus drive enable (low means high impedance) |
| dbus_data | output | 8 | Data bus value, zero when not driven |

## Verification
In ROM wiring, releasing the read strobe while chip select stays low must raise reset_req and start_req in the same cycle. The bench provokes this twice: once after a normal read, and once after a refused read during a conversion. It checks both pulses on the exact third edge, and then checks that the value read next is the newly loaded result. The opposite case is a release where chip select rises in the same clock as the read strobe. This case must yield reset_req alone, and it is checked under both RAM and slow-memory wiring.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_DONE = 2'd2
  } cbus_state_e;

  localparam int CBUS_PIN_W = 2;
endpackage

// File: rtl/cbus_sync.sv
module cbus_sync #(
  parameter int              W       = 2,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  // STAGES flops form the synchronizer, one extra flop holds the prior sample
  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    logic [W-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= g_stage[g-1].q;
      end
    end
  end

  assign lvl_o  = g_stage[STAGES-1].q;
  assign prev_o = g_stage[STAGES].q;
endmodule

// File: rtl/cbus_ctrl.sv
module cbus_ctrl
  import cbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_lvl,
  input  logic        cs_prev,
  input  logic        rd_lvl,
  input  logic        rd_prev,
  input  logic        seq_done,
  output logic        start_req,
  output logic        reset_req,
  output logic        bus_err,
  output logic        capture,
  output cbus_state_e state_q,
  output cbus_state_e state_d
);
  logic cs_fall, rd_rise, rd_fall;
  logic converting, rst_hit, restart, write_hit, misuse;
  logic start_d, reset_d;

  assign cs_fall    = cs_prev & ~cs_lvl;
  assign rd_rise    = rd_lvl & ~rd_prev;
  assign rd_fall    = rd_prev & ~rd_lvl;
  assign converting = (state_q == ST_CONV);

  // release of the read strobe while selected: destructive reset
  assign rst_hit   = rd_rise & ~cs_prev;
  assign restart   = rst_hit & ~cs_lvl;
  // select falling: write cycle when idle or read high; a read when done
  assign write_hit = cs_fall & ~converting & (rd_lvl | (state_q == ST_IDLE));
  // strobe lowered on an already selected, busy converter
  assign misuse    = rd_fall & ~cs_lvl & ~cs_prev & converting;

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    reset_d = 1'b0;
    capture = 1'b0;
    if (rst_hit) begin
      reset_d = 1'b1;
      start_d = restart;
      state_d = restart ? ST_CONV : ST_IDLE;
    end else if (write_hit) begin
      start_d = 1'b1;
      state_d = ST_CONV;
    end else if (converting && seq_done) begin
      capture = 1'b1;
      state_d = ST_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      start_req <= 1'b0;
      reset_req <= 1'b0;
      bus_err   <= 1'b0;
    end else begin
      state_q   <= state_d;
      start_req <= start_d;
      reset_req <= reset_d;
      bus_err   <= misuse;
    end
  end

  a_r11_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  a_r11_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !bus_err);
  a_r10_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (!start_req && !reset_req && state_q == ST_CONV));
  a_r3_start_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !reset_req) |-> $past(state_q != ST_CONV));
endmodule

// File: rtl/cbus_dout.sv
module cbus_dout
  import cbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              rd_lvl,
  input  cbus_state_e       state_d,
  input  logic              capture,
  input  logic [DATA_W-1:0] seq_result,
  output logic              dbus_oe,
  output logic [DATA_W-1:0] dbus_data
);
  logic [DATA_W-1:0] res_q;
  logic              oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      if (capture) res_q <= seq_result;
      // enable follows the state being entered, so it never leads a start
      oe_q <= ~cs_lvl & ~rd_lvl & (state_d != ST_CONV);
    end
  end

  assign dbus_oe   = oe_q;
  assign dbus_data = oe_q ? res_q : '0;

  a_r4_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_oe && $past(dbus_oe)) |-> $stable(dbus_data));
endmodule

// File: rtl/cbus_iface.sv
module cbus_iface
  import cbus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              seq_done,
  input  logic [DATA_W-1:0] seq_result,
  output logic              start_req,
  output logic              reset_req,
  output logic              bus_err,
  output logic              ready_o,
  output logic              dbus_oe,
  output logic [DATA_W-1:0] dbus_data
);
  localparam int PIN_W = CBUS_PIN_W;

  logic [PIN_W-1:0] pin_lvl, pin_prev;
  logic             capture;
  cbus_state_e      state_q, state_d;

  cbus_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({PIN_W{1'b1}})
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({cs_n, rd_n}),
    .lvl_o   (pin_lvl),
    .prev_o  (pin_prev)
  );

  cbus_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_lvl    (pin_lvl[1]),
    .cs_prev   (pin_prev[1]),
    .rd_lvl    (pin_lvl[0]),
    .rd_prev   (pin_prev[0]),
    .seq_done  (seq_done),
    .start_req (start_req),
    .reset_req (reset_req),
    .bus_err   (bus_err),
    .capture   (capture),
    .state_q   (state_q),
    .state_d   (state_d)
  );

  cbus_dout #(.DATA_W(DATA_W)) u_dout (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_lvl     (pin_lvl[1]),
    .rd_lvl     (pin_lvl[0]),
    .state_d    (state_d),
    .capture    (capture),
    .seq_result (seq_result),
    .dbus_oe    (dbus_oe),
    .dbus_data  (dbus_data)
  );

  assign ready_o = (state_q != ST_CONV);

  a_r5_oe_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_oe |-> ready_o);
  a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> !ready_o);
endmodule

// File: tb/cbus_iface_tb.sv
`timescale 1ns/1ps
module cbus_iface_tb;
  localparam int DW       = 8;
  localparam int CONV_CYC = 20;
  localparam logic [2:0] EV_START = 3'b001;
  localparam logic [2:0] EV_RST   = 3'b010;
  localparam logic [2:0] EV_ERR   = 3'b100;

  typedef struct {
    logic [2:0] code;
    string      tag;
  } ev_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, rd_n = 1'b1;
  logic          seq_done;
  logic [DW-1:0] seq_result;
  logic          start_req, reset_req, bus_err, ready_o, dbus_oe;
  logic [DW-1:0] dbus_data;

  int   tests = 0, fails = 0, cnt = 0;
  bit   finished = 0;
  logic [DW-1:0] next_result = '0;
  ev_t  exp_q[$];

  always #10 clk = ~clk;

  cbus_iface #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
    .seq_done(seq_done), .seq_result(seq_result),
    .start_req(start_req), .reset_req(reset_req), .bus_err(bus_err),
    .ready_o(ready_o), .dbus_oe(dbus_oe), .dbus_data(dbus_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input logic c, input logic r);
    cs_n = c;
    rd_n = r;
  endtask

  task automatic expect_ev(input logic [2:0] code, input string tag);
    ev_t e;
    e.code = code;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_ready(input string tag);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (ready_o) break;
    end
    chk(ready_o === 1'b1, tag, ready_o, 1);
  endtask

  // sequencer model: runs CONV_CYC cycles after a start, cancelled by reset
  initial begin
    seq_done = 1'b0;
    seq_result = '0;
    forever begin
      @(negedge clk);
      seq_done = 1'b0;
      if (start_req) cnt = CONV_CYC;
      else if (reset_req) cnt = 0;
      else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          seq_done = 1'b1;
          seq_result = next_result;
        end
      end
    end
  end

  // scoreboard monitor: every request pulse must match the next expected event
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (start_req || reset_req || bus_err)) begin
        logic [2:0] got;
        got = {bus_err, reset_req, start_req};
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected request pulse", got, 0);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(got == e.code, e.tag, got, e.code);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    chk(ready_o === 1'b1, "R1 ready after reset", ready_o, 1);
    chk(dbus_oe === 1'b0, "R1 oe after reset", dbus_oe, 0);
    chk(dbus_data === '0, "R1 data after reset", dbus_data, 0);
    chk({start_req, reset_req, bus_err} === 3'b000, "R1 pulses after reset",
        {start_req, reset_req, bus_err}, 0);

    // RAM wiring: write cycle starts, exact latency
    next_result = 8'hA5;
    expect_ev(EV_START, "R2 write cycle start");
    pins(1'b0, 1'b1);
    tick(2);
    chk(start_req === 1'b0, "R11 start not before third edge", start_req, 0);
    tick(1);
    chk(start_req === 1'b1, "R11 start on third edge", start_req, 1);
    tick(1);
    chk(start_req === 1'b0, "R11 start lasts one cycle", start_req, 0);
    chk(ready_o === 1'b0, "R2 ready low while converting", ready_o, 0);
    pins(1'b1, 1'b1);
    tick(2);
    pins(1'b0, 1'b1);               // second write during conversion
    tick(4);
    chk(ready_o === 1'b0, "R3 ready stays low after ignored write", ready_o, 0);
    pins(1'b1, 1'b1);
    wait_ready("R2 ready returns after done");

    // R6: strobe with chip select high
    pins(1'b1, 1'b0);
    tick(4);
    chk(dbus_oe === 1'b0, "R6 no drive with select high", dbus_oe, 0);
    pins(1'b1, 1'b1);
    tick(4);
    chk(ready_o === 1'b1, "R6 ready unaffected", ready_o, 1);
    pins(1'b1, 1'b0);
    tick(2);

    // RAM read, then release both pins together
    pins(1'b0, 1'b0);
    tick(4);
    chk(dbus_oe === 1'b1, "R4 read drives bus", dbus_oe, 1);
    chk(dbus_data === 8'hA5, "R4 read data", dbus_data, 8'hA5);
    expect_ev(EV_RST, "R7 release with select rising gives reset only");
    pins(1'b1, 1'b1);
    tick(4);
    chk(dbus_oe === 1'b0, "R5 bus released after read", dbus_oe, 0);
    chk(dbus_data === '0, "R5 data zero when released", dbus_data, 0);
    chk(ready_o === 1'b1, "R7 idle after reset", ready_o, 1);

    // ROM wiring: select held low
    next_result = 8'h3C;
    expect_ev(EV_START, "R2 ROM first start");
    pins(1'b0, 1'b1);
    tick(4);
    wait_ready("R2 ROM first done");
    pins(1'b0, 1'b0);
    tick(4);
    chk(dbus_data === 8'h3C, "R4 ROM first read", dbus_data, 8'h3C);
    next_result = 8'hC3;
    expect_ev(EV_RST | EV_START, "R7 ROM release restarts");
    pins(1'b0, 1'b1);
    tick(3);
    chk(reset_req === 1'b1 && start_req === 1'b1, "R7 reset and start same cycle",
        {reset_req, start_req}, 2'b11);
    tick(1);
    chk(ready_o === 1'b0, "R7 converting after restart", ready_o, 0);
    chk(dbus_oe === 1'b0, "R5 no drive with read high", dbus_oe, 0);

    // forbidden read during conversion
    expect_ev(EV_ERR, "R10 read during conversion flagged");
    pins(1'b0, 1'b0);
    tick(3);
    chk(bus_err === 1'b1, "R10 bus_err pulse", bus_err, 1);
    tick(1);
    chk(ready_o === 1'b0, "R10 conversion continues", ready_o, 0);
    chk(dbus_oe === 1'b0, "R5 no drive while converting", dbus_oe, 0);
    expect_ev(EV_RST | EV_START, "R7 release after refused read restarts");
    pins(1'b0, 1'b1);
    tick(4);
    wait_ready("R8 restarted conversion completes");
    pins(1'b0, 1'b0);
    tick(4);
    chk(dbus_data === 8'hC3, "R8 second conversion result read", dbus_data, 8'hC3);
    expect_ev(EV_RST, "R7 ROM exit reset only");
    pins(1'b1, 1'b1);
    tick(4);

    // slow-memory wiring: both pins tied
    next_result = 8'h5A;
    expect_ev(EV_START, "R9 tied fall starts");
    pins(1'b0, 1'b0);
    tick(4);
    chk(ready_o === 1'b0, "R9 wait asserted", ready_o, 0);
    chk(dbus_oe === 1'b0, "R9 no drive during wait", dbus_oe, 0);
    wait_ready("R9 wait released");
    chk(dbus_oe === 1'b1, "R9 drive with ready", dbus_oe, 1);
    chk(dbus_data === 8'h5A, "R9 slow read data", dbus_data, 8'h5A);
    expect_ev(EV_RST, "R9 tied rise resets only");
    pins(1'b1, 1'b1);
    tick(4);
    chk(dbus_oe === 1'b0, "R9 deselected", dbus_oe, 0);
    chk(ready_o === 1'b1, "R9 idle after rise", ready_o, 1);

    tick(30);
    chk(exp_q.size() == 0, "R11 all expected pulses seen", exp_q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule